// File: doc/BRIEF.md
# SPI Controller Status and Control Logic

This block is the register-bus front end of a simple SPI master. It holds a control register, a unit-enable bit in a slave-control register, a transmit word register and a read-only 32-bit status word. Software starts a transfer by writing the transmit word. The block then raises a one-cycle start pulse toward the shift engine and reports busy until the engine returns its done pulse.

While a transfer runs, software may only read the control, slave-control and status registers. Any other access is treated as a protocol violation. The transfer is aborted with a one-cycle pulse to the engine, busy drops and a sticky error flag is raised. The error clears only when software disables the unit.

Completion is reported by a flag that also drives the interrupt pin. Reading the status word clears this flag. The status word sits at byte offset 0x0C. All registers are accessed as whole 32-bit words at word-aligned offsets.

Top module: `spi_stat_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the status word reads 0 and irq, xfer_start and xfer_abort are 0.
- R2: Byte offsets are control 0x00, slave-control 0x04, transmit word 0x08 and status 0x0C. The status word has completion in bit 7, error in bit 2, busy in bit 1 and enable in bit 0, and all other bits read 0. A write to 0x0C has no effect. The control register reads back the low 8 bits written to it.
- R3: A write to 0x08 while the unit is enabled, idle and free of error stores the word, sets busy and gives a one-cycle xfer_start pulse on the next cycle.
- R4: A write to 0x08 while the unit is disabled is ignored: busy stays 0, there is no start pulse and the stored word is unchanged.
- R5: A done pulse while busy sets the completion flag and clears busy, and irq follows the completion flag.
- R6: A read of the status word clears the completion flag and irq from the next cycle on.
- R7: If a done pulse and a status read fall in the same cycle, the completion flag is set afterwards.
- R8: While busy, any write or any read of an address other than 0x00, 0x04 or 0x0C sets the error flag, clears busy and gives a one-cycle xfer_abort pulse. The access has no other effect.
- R9: While busy, reads of 0x00, 0x04 and 0x0C leave busy set and the error flag clear.
- R10: The error flag stays set until a write to 0x04 with bit 0 equal to 0 clears both the enable and the error flag. While the error flag is set, a write to 0x08 starts nothing. Status bit 0 mirrors the enable bit.
- R11: A done pulse while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| xfer_done | input | 1 | Transfer-finished pulse from the shift engine |
| xfer_start | output | 1 | One-cycle start pulse to the shift engine |
| xfer_abort | output | 1 | One-cycle abort pulse to the shift engine |
| tx_word | output | 32 | Stored transmit word |
| irq | output | 1 | Interrupt, equal to the completion flag |

## Verification
The main function, the gating of bus accesses by busy, is tried with three access patterns during a transfer. Permitted reads of the control, slave-control and status registers must leave the transfer running. A data write and a read of an unmapped offset must each abort it. Telling these apart shows that the decode separates allowed from forbidden accesses rather than reacting to every strobe. Further patterns set a done pulse against a status read in the same cycle, a done pulse while idle, and data writes while disabled or in error. These show whether each gate condition is really applied on its own.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_SCTRL = 8'h04;
  localparam logic [7:0] OFF_DATA  = 8'h08;
  localparam logic [7:0] OFF_STAT  = 8'h0C;

  localparam int unsigned BIT_DONE = 7;
  localparam int unsigned BIT_ERR  = 2;
  localparam int unsigned BIT_BUSY = 1;
  localparam int unsigned BIT_EN   = 0;
endpackage

// File: rtl/spi_bus_decode.sv
module spi_bus_decode
  import spi_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              busy,
  output logic              hit_ctrl,
  output logic              hit_sctrl,
  output logic              hit_data,
  output logic              hit_stat,
  output logic              wr_ok,
  output logic              forbidden
);
  logic rd_allowed;

  always_comb begin
    hit_ctrl   = (addr == ADDR_W'(OFF_CTRL));
    hit_sctrl  = (addr == ADDR_W'(OFF_SCTRL));
    hit_data   = (addr == ADDR_W'(OFF_DATA));
    hit_stat   = (addr == ADDR_W'(OFF_STAT));
    rd_allowed = hit_ctrl | hit_sctrl | hit_stat;
    forbidden  = busy & (wr | (rd & ~rd_allowed));
    wr_ok      = wr & ~busy;
  end
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic              hit_ctrl,
  input  logic              hit_sctrl,
  input  logic              hit_data,
  input  logic              err,
  input  logic [DATA_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              en_q,
  output logic [DATA_W-1:0] tx_q,
  output logic              start_req,
  output logic              disable_wr
);
  logic ctrl_ld, en_ld;

  always_comb begin
    ctrl_ld    = wr_ok & hit_ctrl;
    en_ld      = wr_ok & hit_sctrl;
    start_req  = wr_ok & hit_data & en_q & ~err;
    disable_wr = en_ld & ~wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
      tx_q   <= '0;
    end else begin
      if (ctrl_ld)   ctrl_q <= wdata[CTRL_W-1:0];
      if (en_ld)     en_q   <= wdata[0];
      if (start_req) tx_q   <= wdata;
    end
  end
endmodule

// File: rtl/spi_stat_flags.sv
module spi_stat_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic forbidden,
  input  logic xfer_done,
  input  logic stat_rd,
  input  logic disable_wr,
  output logic busy_q,
  output logic done_q,
  output logic err_q,
  output logic start_q,
  output logic abort_q
);
  logic busy_d, done_d, err_d, done_set;

  always_comb begin
    done_set = busy_q & xfer_done & ~forbidden;
    busy_d   = busy_q;
    if (forbidden)     busy_d = 1'b0;
    else if (done_set) busy_d = 1'b0;
    else if (start_req) busy_d = 1'b1;
    done_d = done_q;
    if (done_set)     done_d = 1'b1;
    else if (stat_rd) done_d = 1'b0;
    err_d = err_q;
    if (forbidden)       err_d = 1'b1;
    else if (disable_wr) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      err_q   <= err_d;
      start_q <= start_req;
      abort_q <= forbidden;
    end
  end
endmodule

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
  import spi_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              xfer_done,
  output logic              xfer_start,
  output logic              xfer_abort,
  output logic [DATA_W-1:0] tx_word,
  output logic              irq
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic rst_sn;
  logic hit_ctrl, hit_sctrl, hit_data, hit_stat, wr_ok, forbidden;
  logic busy, done, err, en, start_req, disable_wr;
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sn = rst_pipe[SYNC_STAGES-1];

  spi_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .busy(busy),
    .hit_ctrl(hit_ctrl), .hit_sctrl(hit_sctrl), .hit_data(hit_data),
    .hit_stat(hit_stat), .wr_ok(wr_ok), .forbidden(forbidden)
  );

  spi_ctrl_regs #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_regs (
    .clk(clk), .rst_n(rst_sn), .wr_ok(wr_ok), .hit_ctrl(hit_ctrl),
    .hit_sctrl(hit_sctrl), .hit_data(hit_data), .err(err),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .en_q(en), .tx_q(tx_word),
    .start_req(start_req), .disable_wr(disable_wr)
  );

  spi_stat_flags u_flags (
    .clk(clk), .rst_n(rst_sn), .start_req(start_req), .forbidden(forbidden),
    .xfer_done(xfer_done), .stat_rd(bus_rd & hit_stat),
    .disable_wr(disable_wr), .busy_q(busy), .done_q(done), .err_q(err),
    .start_q(xfer_start), .abort_q(xfer_abort)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_ctrl) begin
        bus_rdata[CTRL_W-1:0] = ctrl_q;
      end else if (hit_sctrl) begin
        bus_rdata[0] = en;
      end else if (hit_data) begin
        bus_rdata = tx_word;
      end else if (hit_stat) begin
        bus_rdata[BIT_DONE] = done;
        bus_rdata[BIT_ERR]  = err;
        bus_rdata[BIT_BUSY] = busy;
        bus_rdata[BIT_EN]   = en;
      end
    end
  end

  assign irq = done;
endmodule

// File: rtl/spi_stat_ctrl_chk.sv
module spi_stat_ctrl_chk
  import spi_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_sn,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              sctrl_bit,
  input logic              xfer_done,
  input logic              xfer_start,
  input logic              xfer_abort,
  input logic              irq,
  input logic              busy,
  input logic              err,
  input logic              en
);
  logic a_stat, a_sctrl, a_data, bad_acc;

  always_comb begin
    a_stat  = (bus_addr == ADDR_W'(OFF_STAT));
    a_sctrl = (bus_addr == ADDR_W'(OFF_SCTRL));
    a_data  = (bus_addr == ADDR_W'(OFF_DATA));
    bad_acc = busy && (bus_wr || (bus_rd && !(a_stat || a_sctrl ||
              bus_addr == ADDR_W'(OFF_CTRL))));
  end

  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    xfer_start |-> busy);

  // R4
  disabled_write_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!en && !busy && bus_wr && a_data) |=> !busy);

  // R5
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && xfer_done && !bad_acc) |=> (irq && !busy));

  // R6
  stat_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_rd && a_stat && !(busy && xfer_done)) |=> !irq);

  // R8
  forbidden_err_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    bad_acc |=> (err && !busy && xfer_abort));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (err && !(bus_wr && a_sctrl && !sctrl_bit && !busy)) |=> err);
endmodule

bind spi_stat_ctrl spi_stat_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .sctrl_bit(bus_wdata[0]), .xfer_done(xfer_done),
  .xfer_start(xfer_start), .xfer_abort(xfer_abort), .irq(irq),
  .busy(busy), .err(err), .en(en)
);

// File: tb/sim_spi_stat_ctrl.sv
module sim_spi_stat_ctrl;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr, bus_rd, xfer_done;
  logic [31:0] bus_wdata, bus_rdata, tx_word;
  logic        xfer_start, xfer_abort, irq;
  int total, bad;
  bit finished;

  spi_stat_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_done(xfer_done), .xfer_start(xfer_start), .xfer_abort(xfer_abort),
    .tx_word(tx_word), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // row: rd, wr, done, addr[8], wdata[32], exp_rdata[32], flags {irq,start,abort}
  localparam int NROW = 13;
  localparam logic [77:0] TAB [0:NROW-1] = '{
    {3'b100, 8'h0C, 32'h0,         32'h0,         3'b000}, // R1
    {3'b010, 8'h04, 32'h1,         32'h0,         3'b000},
    {3'b100, 8'h0C, 32'h0,         32'h1,         3'b000}, // R10 enable mirror
    {3'b010, 8'h0C, 32'hFF,        32'h0,         3'b000},
    {3'b100, 8'h0C, 32'h0,         32'h1,         3'b000}, // R2 status write ignored
    {3'b010, 8'h08, 32'hA5A50001,  32'h0,         3'b000},
    {3'b100, 8'h0C, 32'h0,         32'h3,         3'b010}, // R3
    {3'b100, 8'h00, 32'h0,         32'h0,         3'b000}, // R9
    {3'b100, 8'h04, 32'h0,         32'h1,         3'b000}, // R9
    {3'b001, 8'h00, 32'h0,         32'h0,         3'b000},
    {3'b100, 8'h0C, 32'h0,         32'h81,        3'b100}, // R5
    {3'b100, 8'h0C, 32'h0,         32'h1,         3'b000}, // R6
    {3'b100, 8'h08, 32'h0,         32'hA5A50001,  3'b000}  // R3 stored word
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic rd, input logic wr, input logic dn,
                     input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; xfer_done = dn; bus_addr = a; bus_wdata = d;
    #1;
  endtask

  task automatic flg(input string req, input logic [2:0] exp);
    chk(req, {29'd0, irq, xfer_start, xfer_abort}, {29'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; finished = 0;
    rst_n = 1'b0; bus_rd = 0; bus_wr = 0; xfer_done = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    #1 flg("R1 in reset", 3'b000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NROW; i++) begin
      cyc(TAB[i][77], TAB[i][76], TAB[i][75], TAB[i][74:67], TAB[i][66:35]);
      if (TAB[i][77]) chk($sformatf("table row %0d rdata", i), bus_rdata, TAB[i][34:3]);
      flg($sformatf("table row %0d flags", i), TAB[i][2:0]);
    end

    // R7: done and status read together
    cyc(0, 1, 0, 8'h08, 32'h22);
    cyc(1, 0, 1, 8'h0C, 0);  chk("R7 busy read", bus_rdata, 32'h3);
    cyc(1, 0, 0, 8'h0C, 0);  chk("R7 done kept", bus_rdata, 32'h81); flg("R7 irq", 3'b100);
    cyc(0, 0, 0, 8'h00, 0);  flg("R6 irq cleared", 3'b000);

    // R8: data write during busy
    cyc(0, 1, 0, 8'h08, 32'h1111);
    cyc(0, 1, 0, 8'h08, 32'h2222);
    cyc(1, 0, 0, 8'h0C, 0);  chk("R8 status", bus_rdata, 32'h5); flg("R8 abort", 3'b001);
    cyc(1, 0, 0, 8'h08, 0);  chk("R8 word kept", bus_rdata, 32'h1111); flg("R8 pulse", 3'b000);

    // R10: error sticky, blocks start, cleared by disable
    cyc(0, 1, 0, 8'h08, 32'h3333);
    cyc(1, 0, 0, 8'h0C, 0);  chk("R10 no start in error", bus_rdata, 32'h5); flg("R10 flags", 3'b000);
    cyc(0, 1, 0, 8'h04, 32'h1);
    cyc(1, 0, 0, 8'h0C, 0);  chk("R10 still err", bus_rdata, 32'h5);
    cyc(0, 1, 0, 8'h04, 32'h0);
    cyc(1, 0, 0, 8'h0C, 0);  chk("R10 cleared", bus_rdata, 32'h0);

    // R4: write while disabled
    cyc(0, 1, 0, 8'h08, 32'h4444);
    cyc(1, 0, 0, 8'h0C, 0);  chk("R4 not busy", bus_rdata, 32'h0); flg("R4 no start", 3'b000);
    cyc(1, 0, 0, 8'h08, 0);  chk("R4 word kept", bus_rdata, 32'h1111);

    // R9: allowed reads then unmapped read during busy
    cyc(0, 1, 0, 8'h04, 32'h1);
    cyc(0, 1, 0, 8'h08, 32'h55);
    cyc(1, 0, 0, 8'h00, 0);
    cyc(1, 0, 0, 8'h04, 0);  chk("R9 sctrl read", bus_rdata, 32'h1);
    cyc(1, 0, 0, 8'h0C, 0);  chk("R9 still busy", bus_rdata, 32'h3); flg("R9 no abort", 3'b000);
    cyc(1, 0, 0, 8'h10, 0);
    cyc(1, 0, 0, 8'h0C, 0);  chk("R8 unmapped read", bus_rdata, 32'h5); flg("R8 abort read", 3'b001);

    // R11: done while idle
    cyc(0, 1, 0, 8'h04, 32'h0);
    cyc(0, 1, 0, 8'h04, 32'h1);
    cyc(0, 0, 1, 8'h00, 0);
    cyc(1, 0, 0, 8'h0C, 0);  chk("R11 ignored", bus_rdata, 32'h1); flg("R11 irq", 3'b000);

    // R2: control register readback width
    cyc(0, 1, 0, 8'h00, 32'h1A5);
    cyc(1, 0, 0, 8'h00, 0);  chk("R2 ctrl", bus_rdata, 32'hA5);

    // R1: reset in the middle of a completed transfer
    cyc(0, 1, 0, 8'h08, 32'h9);
    cyc(0, 0, 1, 8'h00, 0);
    cyc(0, 0, 0, 8'h00, 0);  flg("R5 irq before reset", 3'b100);
    @(negedge clk); rst_n = 1'b0; bus_rd = 1; bus_addr = 8'h0C; #1;
    chk("R1 status in reset", bus_rdata, 32'h0); flg("R1 outputs in reset", 3'b000);
    @(negedge clk); rst_n = 1'b1; bus_rd = 0;
    repeat (3) @(negedge clk);
    cyc(1, 0, 0, 8'h0C, 0);  chk("R1 after release", bus_rdata, 32'h0); flg("R1 flags after", 3'b000);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule